// File: doc/BRIEF.md
# Content Subspace Page-Out Controller

This block holds a small level-1 ternary match array and evicts a whole content subspace page from it on request. Each stored entry has a key, a per-bit wildcard mask, a data word and a type bit that separates ordinary data entries from referral entries. A subspace page is the set of data entries whose keys fall inside a region of key space. The region is named by a base key and a page mask, and the page mask may mark any set of key bits as don't care. Uniform pages of 2^k keys are the case where the k lowest bits are masked. Entries of a page may sit anywhere in the array, so the page is found by a ternary search and not by an index range.

After a command is accepted, the controller passes through five states: IDLE, SEARCH, STREAM, WRITE_REF and DONE. IDLE goes to SEARCH when a command is accepted. SEARCH latches the set of matching entries. It goes to STREAM if that set is non-empty and straight to DONE if it is empty. STREAM sends one entry per accepted beat and frees its slot on that same edge. It goes to WRITE_REF after the last beat. WRITE_REF writes a single referral entry into the slot the first evicted entry held. The referral covers the page and carries the level-2 location as its data. It then goes to DONE, which pulses completion for one cycle and returns to IDLE. While a page-out is running, lookups and loads from outside are held off, so a partly evicted page is never visible.

Top module: `subspace_evict`

## Requirements
- R1: After reset every slot is free: no lookup key hits, `pg_ready` is 1, `ev_valid` and `pg_done` are 0.
- R2: In idle, a lookup key hits a valid entry when the key equals the entry key on every bit whose entry mask bit is 0 (mask bit 1 means don't care). Among several hits the lowest slot index wins. `lk_idx`, `lk_data` and `lk_refer` describe that slot, with `lk_refer` 1 for a referral entry.
- R3: A page-out selects exactly the valid, non-referral entries whose key equals `pg_base` on every bit where both the page mask and the entry mask are 0. Any set of bits may be masked, not only the low ones.
- R4: Selected entries leave on the eviction port in ascending slot order, one per cycle in which `ev_valid` and `ev_ready` are both 1. While `ev_ready` is 0, `ev_valid` stays 1 and key, mask and data stay unchanged.
- R5: Each evicted entry is freed on the edge that accepts its beat, so after the page-out no lookup hits it.
- R6: After the last beat exactly one referral entry is written into the slot of the lowest-indexed evicted entry, with key `pg_base`, mask `pg_mask`, data `pg_loc` and type referral. A lookup that hits it returns `lk_refer`=1 and `lk_data`=`pg_loc`.
- R7: `pg_done` is a one-cycle pulse, two cycles after the last accepted beat. A page with no selected entry streams nothing, writes no referral and pulses `pg_done` with `pg_empty`=1; otherwise `pg_empty` is 0.
- R8: From command acceptance until `pg_done` has been seen, `pg_ready` and `lk_ready` are 0, `lk_hit` is 0, and `ld_en` has no effect on the array.
- R9: A load in the same cycle as an accepted command is written before the search, so an entry loaded that way inside the page is evicted with it.
- R10: Entries outside the page and referral entries inside it keep their key, mask, data and type through a page-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load a data entry (taken only in idle) |
| ld_idx | input | IDX_W | Slot to load |
| ld_key | input | KEY_W | Entry key |
| ld_mask | input | KEY_W | Entry wildcard mask, 1 = don't care |
| ld_data | input | DATA_W | Entry data |
| lk_key | input | KEY_W | Binary lookup key |
| lk_ready | output | 1 | Lookup results are valid (idle) |
| lk_hit | output | 1 | Some entry matches the lookup key |
| lk_refer | output | 1 | The winning entry is a referral |
| lk_idx | output | IDX_W | Slot of the winning entry |
| lk_data | output | DATA_W | Data, or level-2 location for a referral |
| pg_valid | input | 1 | Page-out command request |
| pg_ready | output | 1 | Command accepted when both are 1 |
| pg_base | input | KEY_W | Subspace base key |
| pg_mask | input | KEY_W | Subspace mask, 1 = bit ranges freely |
| pg_loc | input | DATA_W | Level-2 location for the referral |
| ev_valid | output | 1 | Evicted entry available |
| ev_ready | input | 1 | Receiver takes the evicted entry |
| ev_key | output | KEY_W | Evicted key |
| ev_mask | output | KEY_W | Evicted wildcard mask |
| ev_data | output | DATA_W | Evicted data |
| pg_done | output | 1 | One-cycle completion pulse |
| pg_empty | output | 1 | With `pg_done`: page had no entries |

## Verification
Two functions can meet on one edge. A load can be written in the same cycle a page-out command is accepted. The bench drives both at once with an entry that falls inside the page and expects that entry among the evicted beats and its slot to end up free or holding the referral. Beat acceptance and invalidation also share an edge, and a load attempted while the receiver stalls must leave the array untouched. This is judged by sweeping all 256 lookup keys after each page-out against a model of the array kept from the requirements.

// File: rtl/sse_pkg.sv
package sse_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_STREAM,
        ST_WREF,
        ST_DONE
    } pg_state_e;

endpackage

// File: rtl/sse_tcam.sv
module sse_tcam #(
    parameter int KEY_W  = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [KEY_W-1:0]  wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_refer,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [KEY_W-1:0]  lk_key,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic              lk_refer,
    output logic [DATA_W-1:0] lk_data,
    input  logic [KEY_W-1:0]  sub_base,
    input  logic [KEY_W-1:0]  sub_mask,
    output logic [DEPTH-1:0]  sub_hits,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [KEY_W-1:0]  rd_key,
    output logic [KEY_W-1:0]  rd_mask,
    output logic [DATA_W-1:0] rd_data
);

    // slot occupancy doubles as the free flag: a cleared bit marks a free slot
    logic [DEPTH-1:0]  vld_q;
    logic [DEPTH-1:0]  ref_q;
    logic [KEY_W-1:0]  key_q  [DEPTH];
    logic [KEY_W-1:0]  mask_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  lk_match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ref_q <= '0;
        end else begin
            if (clr_en) begin
                vld_q[clr_idx] <= 1'b0;
            end
            if (wr_en) begin
                vld_q[wr_idx] <= 1'b1;
                ref_q[wr_idx] <= wr_refer;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            key_q[wr_idx]  <= wr_key;
            mask_q[wr_idx] <= wr_mask;
            data_q[wr_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign lk_match[g] = vld_q[g] &&
                             (((key_q[g] ^ lk_key) & ~mask_q[g]) == '0);
        assign sub_hits[g] = vld_q[g] && !ref_q[g] &&
                             (((key_q[g] ^ sub_base) & ~mask_q[g] & ~sub_mask) == '0);
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (lk_match[i]) begin
                lk_hit = 1'b1;
                lk_idx = IDX_W'(i);
            end
        end
    end

    assign lk_refer = ref_q[lk_idx];
    assign lk_data  = data_q[lk_idx];
    assign rd_key   = key_q[rd_idx];
    assign rd_mask  = mask_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

endmodule

// File: rtl/sse_ctrl.sv
module sse_ctrl
    import sse_pkg::*;
#(
    parameter int KEY_W  = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_valid,
    output logic              pg_ready,
    input  logic [KEY_W-1:0]  pg_base,
    input  logic [KEY_W-1:0]  pg_mask,
    input  logic [DATA_W-1:0] pg_loc,
    input  logic [DEPTH-1:0]  sub_hits,
    output logic [KEY_W-1:0]  sub_base,
    output logic [KEY_W-1:0]  sub_mask,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic [IDX_W-1:0]  head_idx,
    output logic              clr_en,
    output logic              ref_wr,
    output logic [IDX_W-1:0]  ref_idx,
    output logic [DATA_W-1:0] ref_loc,
    output logic              busy,
    output logic              pg_done,
    output logic              pg_empty
);

    pg_state_e         st_q, st_d;
    logic [KEY_W-1:0]  base_q, mask_q;
    logic [DATA_W-1:0] loc_q;
    logic [DEPTH-1:0]  pend_q, pend_rest;
    logic [IDX_W-1:0]  slot_q;
    logic              took_q, empty_q, beat;

    // lowest pending slot goes out first
    always_comb begin
        head_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                head_idx = IDX_W'(i);
            end
        end
    end

    assign pend_rest = pend_q & ~(DEPTH'(1) << head_idx);
    assign beat      = (st_q == ST_STREAM) && ev_ready;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (pg_valid) st_d = ST_SEARCH;
            ST_SEARCH: st_d = (sub_hits == '0) ? ST_DONE : ST_STREAM;
            ST_STREAM: if (beat && pend_rest == '0) st_d = ST_WREF;
            ST_WREF:   st_d = ST_DONE;
            ST_DONE:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            base_q  <= '0;
            mask_q  <= '0;
            loc_q   <= '0;
            pend_q  <= '0;
            slot_q  <= '0;
            took_q  <= 1'b0;
            empty_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && pg_valid) begin
                base_q <= pg_base;
                mask_q <= pg_mask;
                loc_q  <= pg_loc;
                took_q <= 1'b0;
            end
            if (st_q == ST_SEARCH) begin
                pend_q  <= sub_hits;
                empty_q <= (sub_hits == '0);
            end
            if (beat) begin
                pend_q <= pend_rest;
                if (!took_q) begin
                    slot_q <= head_idx;
                    took_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        pg_ready = 1'b0;
        ev_valid = 1'b0;
        clr_en   = 1'b0;
        ref_wr   = 1'b0;
        pg_done  = 1'b0;
        pg_empty = 1'b0;
        unique case (st_q)
            ST_IDLE:   pg_ready = 1'b1;
            ST_SEARCH: ;
            ST_STREAM: begin
                ev_valid = 1'b1;
                clr_en   = ev_ready;
            end
            ST_WREF:   ref_wr = 1'b1;
            ST_DONE: begin
                pg_done  = 1'b1;
                pg_empty = empty_q;
            end
            default: ;
        endcase
    end

    assign busy     = (st_q != ST_IDLE);
    assign sub_base = base_q;
    assign sub_mask = mask_q;
    assign ref_idx  = slot_q;
    assign ref_loc  = loc_q;

endmodule

// File: rtl/subspace_evict.sv
module subspace_evict #(
    parameter int KEY_W  = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [KEY_W-1:0]  ld_key,
    input  logic [KEY_W-1:0]  ld_mask,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [KEY_W-1:0]  lk_key,
    output logic              lk_ready,
    output logic              lk_hit,
    output logic              lk_refer,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [DATA_W-1:0] lk_data,
    input  logic              pg_valid,
    output logic              pg_ready,
    input  logic [KEY_W-1:0]  pg_base,
    input  logic [KEY_W-1:0]  pg_mask,
    input  logic [DATA_W-1:0] pg_loc,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic [KEY_W-1:0]  ev_key,
    output logic [KEY_W-1:0]  ev_mask,
    output logic [DATA_W-1:0] ev_data,
    output logic              pg_done,
    output logic              pg_empty
);

    logic              busy, ref_wr, clr_en, raw_hit, raw_refer;
    logic              t_wr_en;
    logic [IDX_W-1:0]  ref_idx, head_idx, t_wr_idx;
    logic [DATA_W-1:0] ref_loc, t_wr_data;
    logic [KEY_W-1:0]  sub_base, sub_mask, t_wr_key, t_wr_mask;
    logic [DEPTH-1:0]  sub_hits;

    // loads only land in idle; the referral write owns the port in WRITE_REF
    assign t_wr_en   = ref_wr || (pg_ready && ld_en);
    assign t_wr_idx  = ref_wr ? ref_idx  : ld_idx;
    assign t_wr_key  = ref_wr ? sub_base : ld_key;
    assign t_wr_mask = ref_wr ? sub_mask : ld_mask;
    assign t_wr_data = ref_wr ? ref_loc  : ld_data;

    sse_tcam #(.KEY_W(KEY_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (t_wr_en),
        .wr_idx   (t_wr_idx),
        .wr_key   (t_wr_key),
        .wr_mask  (t_wr_mask),
        .wr_data  (t_wr_data),
        .wr_refer (ref_wr),
        .clr_en   (clr_en),
        .clr_idx  (head_idx),
        .lk_key   (lk_key),
        .lk_hit   (raw_hit),
        .lk_idx   (lk_idx),
        .lk_refer (raw_refer),
        .lk_data  (lk_data),
        .sub_base (sub_base),
        .sub_mask (sub_mask),
        .sub_hits (sub_hits),
        .rd_idx   (head_idx),
        .rd_key   (ev_key),
        .rd_mask  (ev_mask),
        .rd_data  (ev_data)
    );

    sse_ctrl #(.KEY_W(KEY_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pg_valid (pg_valid),
        .pg_ready (pg_ready),
        .pg_base  (pg_base),
        .pg_mask  (pg_mask),
        .pg_loc   (pg_loc),
        .sub_hits (sub_hits),
        .sub_base (sub_base),
        .sub_mask (sub_mask),
        .ev_valid (ev_valid),
        .ev_ready (ev_ready),
        .head_idx (head_idx),
        .clr_en   (clr_en),
        .ref_wr   (ref_wr),
        .ref_idx  (ref_idx),
        .ref_loc  (ref_loc),
        .busy     (busy),
        .pg_done  (pg_done),
        .pg_empty (pg_empty)
    );

    assign lk_ready = !busy;
    assign lk_hit   = raw_hit && !busy;
    assign lk_refer = raw_hit && !busy && raw_refer;

endmodule

// File: rtl/sse_checker.sv
module sse_checker #(
    parameter int KEY_W  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pg_valid,
    input logic              pg_ready,
    input logic              lk_ready,
    input logic              lk_hit,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [KEY_W-1:0]  ev_key,
    input logic [KEY_W-1:0]  ev_mask,
    input logic [DATA_W-1:0] ev_data,
    input logic              pg_done,
    input logic              pg_empty
);

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_ready |=> ev_valid && $stable(ev_key) && $stable(ev_mask) && $stable(ev_data)); // R4

    AST_SEARCH_BEFORE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        pg_valid && pg_ready |=> !ev_valid && !pg_ready && !pg_done); // R4

    AST_STREAM_BLOCKS_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> !pg_ready && !lk_ready); // R8

    AST_NO_HIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_ready |-> !lk_hit); // R8

    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pg_done |=> !pg_done && pg_ready); // R7

    AST_EMPTY_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pg_empty |-> pg_done && !ev_valid); // R7

endmodule

bind subspace_evict sse_checker #(.KEY_W(KEY_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pg_valid (pg_valid),
    .pg_ready (pg_ready),
    .lk_ready (lk_ready),
    .lk_hit   (lk_hit),
    .ev_valid (ev_valid),
    .ev_ready (ev_ready),
    .ev_key   (ev_key),
    .ev_mask  (ev_mask),
    .ev_data  (ev_data),
    .pg_done  (pg_done),
    .pg_empty (pg_empty)
);

// File: tb/subspace_evict_tb.sv
module subspace_evict_tb;

    localparam int CLK_PERIOD = 10;
    localparam int KW = 8;
    localparam int DW = 8;
    localparam int DEP = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [KW-1:0] ld_key = '0, ld_mask = '0;
    logic [DW-1:0] ld_data = '0;
    logic [KW-1:0] lk_key = '0;
    logic          lk_ready, lk_hit, lk_refer;
    logic [IW-1:0] lk_idx;
    logic [DW-1:0] lk_data;
    logic          pg_valid = 1'b0, pg_ready;
    logic [KW-1:0] pg_base = '0, pg_mask = '0;
    logic [DW-1:0] pg_loc = '0;
    logic          ev_valid, ev_ready = 1'b0;
    logic [KW-1:0] ev_key, ev_mask;
    logic [DW-1:0] ev_data;
    logic          pg_done, pg_empty;

    int n_chk = 0;
    int n_err = 0;

    // model of the array, kept from the requirements
    bit            m_v [DEP];
    bit            m_r [DEP];
    logic [KW-1:0] m_k [DEP];
    logic [KW-1:0] m_m [DEP];
    logic [DW-1:0] m_d [DEP];

    always #(CLK_PERIOD / 2) clk = ~clk;

    subspace_evict #(.KEY_W(KW), .DATA_W(DW), .DEPTH(DEP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_key(ld_key), .ld_mask(ld_mask), .ld_data(ld_data),
        .lk_key(lk_key), .lk_ready(lk_ready), .lk_hit(lk_hit), .lk_refer(lk_refer),
        .lk_idx(lk_idx), .lk_data(lk_data),
        .pg_valid(pg_valid), .pg_ready(pg_ready), .pg_base(pg_base), .pg_mask(pg_mask),
        .pg_loc(pg_loc),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_key(ev_key), .ev_mask(ev_mask),
        .ev_data(ev_data),
        .pg_done(pg_done), .pg_empty(pg_empty)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [KW-1:0] k, input logic [KW-1:0] m, input logic [DW-1:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = IW'(idx); ld_key = k; ld_mask = m; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        m_v[idx] = 1'b1; m_r[idx] = 1'b0; m_k[idx] = k; m_m[idx] = m; m_d[idx] = d;
    endtask

    function automatic logic [31:0] model_lookup(input logic [KW-1:0] key);
        for (int i = 0; i < DEP; i++) begin
            if (m_v[i] && (((m_k[i] ^ key) & ~m_m[i]) == '0))
                return {19'd0, 1'b1, IW'(i), m_r[i], m_d[i]};
        end
        return '0;
    endfunction

    // R2 R5 R6 R10: every lookup key against the model
    task automatic sweep(input string req);
        for (int key = 0; key < 256; key++) begin
            logic [31:0] act;
            logic [31:0] exp;
            lk_key = KW'(key);
            #1;
            act = lk_hit ? {19'd0, 1'b1, lk_idx, lk_refer, lk_data} : 32'd0;
            exp = model_lookup(KW'(key));
            check(act == exp, req, act, exp);
        end
    endtask

    function automatic bit in_page(input int i, input logic [KW-1:0] b, input logic [KW-1:0] m);
        return m_v[i] && !m_r[i] && (((m_k[i] ^ b) & ~m_m[i] & ~m) == '0);
    endfunction

    task automatic run_page(input logic [KW-1:0] b, input logic [KW-1:0] m, input logic [DW-1:0] loc,
                            input bit stall, input bit inject, input bit same_ld,
                            input logic [KW-1:0] same_key, input string req);
        int exp_idx[DEP];
        int n_exp = 0;
        int beats = 0;
        bit seen_done = 1'b0;
        bit empty_seen = 1'b0;
        @(negedge clk);
        pg_valid = 1'b1; pg_base = b; pg_mask = m; pg_loc = loc;
        lk_key = b;
        if (same_ld) begin
            ld_en = 1'b1; ld_idx = 3'd7; ld_key = same_key; ld_mask = '0; ld_data = 8'hE7;
            m_v[7] = 1'b1; m_r[7] = 1'b0; m_k[7] = same_key; m_m[7] = '0; m_d[7] = 8'hE7;
        end
        for (int i = 0; i < DEP; i++) begin
            if (in_page(i, b, m)) begin
                exp_idx[n_exp] = i;
                n_exp++;
            end
        end
        @(negedge clk);
        pg_valid = 1'b0; ld_en = 1'b0;
        check(!pg_ready && !lk_ready, "R8 not ready after accept", {pg_ready, lk_ready}, 0);
        for (int cyc = 0; cyc < 60 && !seen_done; cyc++) begin
            if (pg_done) begin
                seen_done = 1'b1;
                empty_seen = pg_empty;
            end else begin
                bit rdy;
                check(!lk_ready && !lk_hit && !pg_ready, "R8 lookup held off", {lk_ready, lk_hit, pg_ready}, 0);
                rdy = stall ? ((cyc % 2) == 1) : 1'b1;
                if (ev_valid && rdy) begin
                    logic [31:0] act;
                    logic [31:0] exp;
                    act = {8'd0, ev_key, ev_mask, ev_data};
                    exp = (beats < n_exp) ? {8'd0, m_k[exp_idx[beats]], m_m[exp_idx[beats]], m_d[exp_idx[beats]]} : 32'hFFFF_FFFF;
                    check(act == exp, {req, " R4 beat content"}, act, exp);
                    beats++;
                end
                if (inject && cyc == 2) begin
                    ld_en = 1'b1; ld_idx = 3'd7; ld_key = 8'h99; ld_mask = '0; ld_data = 8'hBB;
                end else begin
                    ld_en = 1'b0;
                end
                ev_ready = rdy;
                @(negedge clk);
            end
        end
        ev_ready = 1'b0; ld_en = 1'b0;
        check(seen_done, {req, " R7 done pulse"}, 32'(seen_done), 1);
        check(beats == n_exp, {req, " R4 beat count"}, beats, n_exp);
        check(empty_seen == (n_exp == 0), {req, " R7 empty flag"}, 32'(empty_seen), 32'(n_exp == 0));
        for (int j = 0; j < n_exp; j++) m_v[exp_idx[j]] = 1'b0;
        if (n_exp > 0) begin
            m_v[exp_idx[0]] = 1'b1; m_r[exp_idx[0]] = 1'b1;
            m_k[exp_idx[0]] = b; m_m[exp_idx[0]] = m; m_d[exp_idx[0]] = loc;
        end
        @(negedge clk);
        check(pg_ready && lk_ready, {req, " R7 back to idle"}, {pg_ready, lk_ready}, 2'b11);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pg_ready && !ev_valid && !pg_done, "R1 idle after reset", {pg_ready, ev_valid, pg_done}, 3'b100);
        sweep("R1 all slots free");
    endtask

    task automatic t_lookup;
        load(0, 8'h10, 8'h00, 8'hA0);
        load(1, 8'h35, 8'h00, 8'hA1);
        load(2, 8'h12, 8'h01, 8'hA2);
        load(3, 8'h80, 8'h0F, 8'hA3);
        load(4, 8'h13, 8'h00, 8'hA4);
        load(5, 8'h5A, 8'h00, 8'hA5);
        load(6, 8'h17, 8'h00, 8'hA6);
        lk_key = 8'h13;
        #1;
        check(lk_hit && lk_idx == 3'd2 && lk_data == 8'hA2, "R2 lowest index wins", {lk_hit, lk_idx, lk_data}, {1'b1, 3'd2, 8'hA2});
        sweep("R2 ternary lookup");
    endtask

    task automatic t_low_bits_page;
        // low three bits masked, receiver stalls, a load is attempted mid-page
        run_page(8'h10, 8'h07, 8'hC1, 1'b1, 1'b1, 1'b0, 8'h00, "low-bit page");
        sweep("R5 R6 R8 R10 after low-bit page");
        lk_key = 8'h99;
        #1;
        check(!lk_hit, "R8 busy load ignored", 32'(lk_hit), 0);
        lk_key = 8'h16;
        #1;
        check(lk_hit && lk_refer && lk_data == 8'hC1 && lk_idx == 3'd0, "R6 referral in first slot",
              {lk_hit, lk_refer, lk_idx, lk_data}, {1'b1, 1'b1, 3'd0, 8'hC1});
    endtask

    task automatic t_scattered_page;
        load(7, 8'h95, 8'h00, 8'hA7);
        // bits 7 and 5 masked: selects slots 1 and 7, skips the referral in slot 0
        run_page(8'h15, 8'hA0, 8'hC2, 1'b0, 1'b0, 1'b0, 8'h00, "scattered page");
        sweep("R3 R10 after scattered page");
    endtask

    task automatic t_empty_page;
        run_page(8'h40, 8'h0F, 8'hC3, 1'b0, 1'b0, 1'b0, 8'h00, "empty page");
        sweep("R7 empty page leaves array");
    endtask

    task automatic t_same_cycle_load;
        run_page(8'h58, 8'h03, 8'hC4, 1'b1, 1'b0, 1'b1, 8'h5B, "same-cycle load");
        sweep("R9 same-cycle load evicted");
    endtask

    initial begin
        for (int i = 0; i < DEP; i++) begin
            m_v[i] = 1'b0; m_r[i] = 1'b0; m_k[i] = '0; m_m[i] = '0; m_d[i] = '0;
        end
        t_reset();
        t_lookup();
        t_low_bits_page();
        t_scattered_page();
        t_empty_page();
        t_same_cycle_load();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule